// File: doc/BRIEF.md
# Key-Protected Clock Control Register File

This block is a small register file that holds the control bits for a clock generator. It does not make or switch clocks. It drives four static control outputs to a separate clock switching block: the oscillator source select, the CPU clock divide select, the oscillation-wait option for wake from sleep, and the HALT mode option.

A simple synchronous bus port reaches three registers: an 8-bit protect key, a power control register and a clock option register. A write to either control register only changes its fields while the key register holds the unlock pattern 0b10010110 (0x96). The key register itself can always be written and read, and it resets to 0x00, so the controls start locked. Software writes 0x96 to the key, updates the controls, then writes any other value to lock them again.

Top module: `clkctl_keyregs`

## Requirements
- R1: After reset, the key reads 0x00, the source select is 1 (fast oscillator), the divide select is 00 (divide by 1), the wait bit is 1 and the HALT option is 0 (basic HALT).
- R2: A write to KEY_ADDR stores all 8 data bits in the key register at any time, and that value reads back at KEY_ADDR.
- R3: While the key holds 0x96, a write to PWR_ADDR loads the source select from data bit 2 and the divide select from data bits 7:6.
- R4: While the key holds 0x96, a write to OPT_ADDR loads the wait bit from data bit 2 and the HALT option from data bit 3.
- R5: While the key holds any value other than 0x96, including each pattern one bit away from it, writes to PWR_ADDR and OPT_ADDR leave all four control fields unchanged.
- R6: Read data is combinational from the address. PWR_ADDR returns the divide select in bits 7:6 and the source select in bit 2. OPT_ADDR returns the HALT option in bit 3 and the wait bit in bit 2. All other bits of both registers read 0, whatever was written. Unmapped addresses read 0x00. Reads do not depend on the key.
- R7: The control outputs equal the stored fields, so an accepted write shows on them from the clock edge that accepts it.
- R8: The key stays at 0x96 across any number of control writes, and it only changes when KEY_ADDR is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 8 | Read data for bus_addr |
| src_fast | output | 1 | 1 selects the fast oscillator, 0 selects the slow one |
| div_sel | output | 2 | Fast clock divide select: 00 = /1, 01 = /2, 10 = /4, 11 = /8 |
| osc_wait_off | output | 1 | 1 turns the oscillation-wait option off, 0 turns it on |
| halt_deep | output | 1 | 1 selects the deep HALT mode, 0 selects basic HALT |

## Verification
The bench builds the block with its default parameters: an 8-bit address, the key at 0x00, the power register at 0x80, the option register at 0x90 and an unlock value of 0x96. With these defaults all eight key values that differ from 0x96 in one bit can be tried against both control registers. The reserved bits and an unmapped address can also be exercised, and relocking can be checked, all within a few hundred cycles.

// File: rtl/clkctl_keyregs.sv
module clkctl_keyregs #(
  parameter int         ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] PWR_ADDR = 'h80,
  parameter logic [ADDR_W-1:0] OPT_ADDR = 'h90,
  parameter logic [7:0] UNLOCK   = 8'b1001_0110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rdata,
  output logic              src_fast,
  output logic [1:0]        div_sel,
  output logic              osc_wait_off,
  output logic              halt_deep
);

  logic [7:0] key_q;
  logic       src_q, wait_q, halt_q;
  logic [1:0] div_q;

  wire unlocked = (key_q == UNLOCK);
  wire wr_key   = bus_we && (bus_addr == KEY_ADDR);
  wire wr_pwr   = bus_we && (bus_addr == PWR_ADDR) && unlocked;
  wire wr_opt   = bus_we && (bus_addr == OPT_ADDR) && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= 8'h00;
      src_q  <= 1'b1;
      div_q  <= 2'b00;
      wait_q <= 1'b1;
      halt_q <= 1'b0;
    end else begin
      if (wr_key) key_q <= bus_wdata;
      if (wr_pwr) begin
        src_q <= bus_wdata[2];
        div_q <= bus_wdata[7:6];
      end
      if (wr_opt) begin
        wait_q <= bus_wdata[2];
        halt_q <= bus_wdata[3];
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == KEY_ADDR)      bus_rdata = key_q;
    else if (bus_addr == PWR_ADDR) bus_rdata = {div_q, 3'b000, src_q, 2'b00};
    else if (bus_addr == OPT_ADDR) bus_rdata = {4'h0, halt_q, wait_q, 2'b00};
  end

  assign src_fast     = src_q;
  assign div_sel      = div_q;
  assign osc_wait_off = wait_q;
  assign halt_deep    = halt_q;

  AST_KEY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == KEY_ADDR) |=> (bus_rdata == $past(bus_wdata) || bus_addr != KEY_ADDR)); // R2
  AST_PWR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == PWR_ADDR && key_q == UNLOCK) |=> (src_fast == $past(bus_wdata[2]) && div_sel == $past(bus_wdata[7:6]))); // R3
  AST_OPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OPT_ADDR && key_q == UNLOCK) |=> (osc_wait_off == $past(bus_wdata[2]) && halt_deep == $past(bus_wdata[3]))); // R4
  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (key_q != UNLOCK) |=> ($stable(src_fast) && $stable(div_sel) && $stable(osc_wait_off) && $stable(halt_deep))); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OPT_ADDR) |-> (bus_rdata[7:4] == 4'h0 && bus_rdata[1:0] == 2'b00)); // R6
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == KEY_ADDR) |=> $stable(key_q)); // R8

endmodule

// File: tb/clkctl_keyregs_tb.sv
`timescale 1ns/1ps
module clkctl_keyregs_tb;
  localparam logic [7:0] KA = 8'h00, PA = 8'h80, OA = 8'h90, UNL = 8'h96;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic src_fast, osc_wait_off, halt_deep;
  logic [1:0] div_sel;
  int errors = 0, checks = 0;
  bit done = 0;

  int m_key, m_src, m_div, m_wait, m_halt;

  always #4 clk = ~clk;

  clkctl_keyregs u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .src_fast(src_fast), .div_sel(div_sel),
    .osc_wait_off(osc_wait_off), .halt_deep(halt_deep));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_key = 0; m_src = 1; m_div = 0; m_wait = 1; m_halt = 0;
    end else if (bus_we) begin
      if (bus_addr == KA) m_key = bus_wdata;
      else if (bus_addr == PA && m_key == UNL) begin
        m_src = (bus_wdata >> 2) & 1; m_div = (bus_wdata >> 6) & 3;
      end else if (bus_addr == OA && m_key == UNL) begin
        m_wait = (bus_wdata >> 2) & 1; m_halt = (bus_wdata >> 3) & 1;
      end
    end
  end

  function automatic int exp_read(int a);
    if (a == KA) return m_key;
    if (a == PA) return m_div * 64 + m_src * 4;
    if (a == OA) return m_halt * 8 + m_wait * 4;
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3/R7 src", src_fast, m_src);
    chk("R3/R7 div", div_sel, m_div);
    chk("R4/R7 wait", osc_wait_off, m_wait);
    chk("R4/R7 halt", halt_deep, m_halt);
    chk("R6 rdata", bus_rdata, exp_read(bus_addr));
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, string req, int exp);
    @(negedge clk); #1;
    bus_addr = a;
    #1 chk(req, bus_rdata, exp);
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(KA, "R1 key", 8'h00);
    rd(PA, "R1 pwr", 8'h04);
    rd(OA, "R1 opt", 8'h04);
    chk("R1 src", src_fast, 1); chk("R1 div", div_sel, 0);
    chk("R1 wait", osc_wait_off, 1); chk("R1 halt", halt_deep, 0);
    // R5 writes while locked at reset
    wr(PA, 8'hC0); wr(OA, 8'h08);
    rd(PA, "R5 locked pwr", 8'h04);
    rd(OA, "R5 locked opt", 8'h04);
    // R5 one bit away from unlock
    for (int b = 0; b < 8; b++) begin
      wr(KA, UNL ^ (8'h1 << b));
      rd(KA, "R2 key readback", UNL ^ (8'h1 << b));
      wr(PA, 8'hC0); wr(OA, 8'h08);
      chk("R5 src held", src_fast, 1); chk("R5 div held", div_sel, 0);
      chk("R5 wait held", osc_wait_off, 1); chk("R5 halt held", halt_deep, 0);
    end
    // R3 R4 unlocked writes
    wr(KA, UNL);
    for (int d = 0; d < 4; d++) begin
      wr(PA, 8'(d * 64 + 8'h3B));
      chk("R3 div", div_sel, d); chk("R3 src", src_fast, 0);
      wr(PA, 8'(d * 64 + 8'h04));
      chk("R3 src set", src_fast, 1);
    end
    wr(OA, 8'hFF);
    chk("R4 halt", halt_deep, 1); chk("R4 wait", osc_wait_off, 1);
    rd(OA, "R6 reserved opt", 8'h0C);
    wr(OA, 8'hF3);
    chk("R4 both clear", {halt_deep, osc_wait_off}, 0);
    wr(PA, 8'h7B);
    rd(PA, "R6 reserved pwr", 8'h40);
    rd(8'h44, "R6 unmapped", 8'h00);
    // R8 key persists
    rd(KA, "R8 key kept", UNL);
    wr(OA, 8'h08);
    chk("R8 still unlocked", halt_deep, 1);
    // relock
    wr(KA, 8'h00);
    wr(PA, 8'hC4); wr(OA, 8'h04);
    chk("R5 relock div", div_sel, 1); chk("R5 relock src", src_fast, 0);
    chk("R5 relock halt", halt_deep, 1); chk("R5 relock wait", osc_wait_off, 0);
    // R1 reset again
    @(negedge clk); rst_n = 0; #1;
    chk("R1 async src", src_fast, 1); chk("R1 async div", div_sel, 0);
    chk("R1 async halt", halt_deep, 0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule